// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives a host processor byte or word access to a packet buffer through one data port. Software first sets a current address and a remaining byte count through a small byte-wide register interface. It then issues a series of accesses on the data port. Each access moves one byte or one 16-bit word, depending on a configuration bit. After each access the block steps the address, folds it back into the receive ring when it reaches the ring's stop page, and reduces the count. When the count is used up, the block raises a completion flag.

The packet buffer itself lives outside the block, behind a 16-bit RAM port with byte enables and one cycle of read latency. Only two address windows reach that RAM: a small low region and a large high region. Accesses outside them leave the RAM untouched, and reads there return all ones. Word accesses ignore address bit 0 and use little-endian lane order. The completion flag is a raw status bit; masking it into an interrupt is left to the surrounding logic.

Top module: `rdma_host_port`

## Requirements
- R1: After reset the current address, the remaining count, both ring pages, the configuration and the completion flag are 0, and `host_rvalid` is low.
- R2: The register map is: offset 0 command, 1 ring start page, 2 ring stop page, 3 address low byte, 4 address high byte, 5 count low byte, 6 count high byte, 7 configuration, 8 status. Offsets 3 to 6 and 8 read back the live values. Status bit 6 is the completion flag, and writing offset 8 with bit 6 set clears it.
- R3: Configuration bit 0 set selects word transfers of size 2; clear selects byte transfers of size 1. Each accepted access adds the transfer size to the current address.
- R4: If the stepped address equals the stop page times 256, the address is reloaded with the start page times 256.
- R5: If the count is at or below the transfer size when an access is accepted, the count becomes 0 and the completion flag is set. Otherwise the count drops by the transfer size.
- R6: A data-port write while the count is 0 is ignored. No RAM cycle is issued, and the address and count do not change.
- R7: Writing the command register with bit 3 (remote read) or bit 4 (remote write) set while the count is 0 sets the completion flag in the next cycle. With a non-zero count, no flag is set.
- R8: The RAM is reached only for byte addresses below 32 or from 16384 up to 49151. Outside those windows, writes issue no RAM cycle, byte reads return 16'h00FF and word reads return 16'hFFFF. The address and count still advance.
- R9: A word access drives the word address with address bit 0 cleared and `mem_be` = 2'b11. The byte at the even address travels in bits 7:0.
- R10: A byte access enables lane 0 (`mem_be` 2'b01) at an even address and lane 1 (2'b10) at an odd address. The write byte is copied onto both lanes, and read data returns the selected lane in bits 7:0 with 0 in bits 15:8.
- R11: Read data appears on `host_rdata` with `host_rvalid` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| host_req | input | 1 | Data-port access request, one per cycle |
| host_we | input | 1 | Data-port access is a write |
| host_wdata | input | 16 | Data-port write data |
| host_rdata | output | 16 | Data-port read data |
| host_rvalid | output | 1 | Read data valid |
| mem_en | output | 1 | RAM cycle enable |
| mem_we | output | 1 | RAM write |
| mem_be | output | 2 | RAM byte-lane enables |
| mem_addr | output | 15 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after the request |
| dma_done | output | 1 | Completion flag |

## Verification
The assertions check several properties on every cycle. The RAM is never enabled outside its two windows, and never by a write while the count is 0. Lane enables match the transfer size. Each ordinary access lowers the count by exactly that size. Every read request is answered one cycle later. Wrap-around at the stop page, little-endian lane placement of returned data, the all-ones fill for reads outside the windows, the immediate completion of a zero-count command, and the window boundaries at 31/32 and 16383/16384/49151/49152 can only be shown by the bench's directed sequences, which compare data values against hand-computed results.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        REG_CMD     = 4'd0,
        REG_PSTART  = 4'd1,
        REG_PSTOP   = 4'd2,
        REG_ADDR_LO = 4'd3,
        REG_ADDR_HI = 4'd4,
        REG_CNT_LO  = 4'd5,
        REG_CNT_HI  = 4'd6,
        REG_CFG     = 4'd7,
        REG_STAT    = 4'd8
    } reg_sel_e;

    localparam int CMD_RD_BIT   = 3;
    localparam int CMD_WR_BIT   = 4;
    localparam int STAT_DONE_BIT = 6;
    localparam int CFG_WORD_BIT = 0;

    // byte-wide load strobes for the address and count registers
    typedef struct packed {
        logic addr_lo;
        logic addr_hi;
        logic cnt_lo;
        logic cnt_hi;
    } ld_strobe_t;

    // registered context of a pending read response
    typedef struct packed {
        logic valid;
        logic hit;
        logic word;
        logic lane;
    } rd_ctx_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic done);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[STAT_DONE_BIT] = done;
        return s;
    endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic [ADDR_W-1:0]    cur_addr,
    input  logic [ADDR_W-1:0]    cur_cnt,
    input  logic                 done,
    output logic [ADDR_W-9:0]    start_page,
    output logic [ADDR_W-9:0]    stop_page,
    output logic                 word_mode,
    output ld_strobe_t           ld,
    output logic                 kick,
    output logic                 stat_clr
);
    localparam int PG_W = ADDR_W - 8;

    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] cfg_q;
    logic [PG_W-1:0]   pstart_q;
    logic [PG_W-1:0]   pstop_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            cfg_q    <= '0;
            pstart_q <= '0;
            pstop_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                REG_CMD:    cmd_q    <= reg_wdata;
                REG_CFG:    cfg_q    <= reg_wdata;
                REG_PSTART: pstart_q <= reg_wdata[PG_W-1:0];
                REG_PSTOP:  pstop_q  <= reg_wdata[PG_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        ld.addr_lo = reg_wr && (sel == REG_ADDR_LO);
        ld.addr_hi = reg_wr && (sel == REG_ADDR_HI);
        ld.cnt_lo  = reg_wr && (sel == REG_CNT_LO);
        ld.cnt_hi  = reg_wr && (sel == REG_CNT_HI);
        kick       = reg_wr && (sel == REG_CMD) &&
                     (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
        stat_clr   = reg_wr && (sel == REG_STAT) && reg_wdata[STAT_DONE_BIT];
    end

    always_comb begin
        case (sel)
            REG_CMD:     reg_rdata = cmd_q;
            REG_PSTART:  reg_rdata = BYTE_W'(pstart_q);
            REG_PSTOP:   reg_rdata = BYTE_W'(pstop_q);
            REG_ADDR_LO: reg_rdata = cur_addr[7:0];
            REG_ADDR_HI: reg_rdata = BYTE_W'(cur_addr >> 8);
            REG_CNT_LO:  reg_rdata = cur_cnt[7:0];
            REG_CNT_HI:  reg_rdata = BYTE_W'(cur_cnt >> 8);
            REG_CFG:     reg_rdata = cfg_q;
            REG_STAT:    reg_rdata = status_byte(done);
            default:     reg_rdata = '0;
        endcase
    end

    assign start_page = pstart_q;
    assign stop_page  = pstop_q;
    assign word_mode  = cfg_q[CFG_WORD_BIT];

endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ld_strobe_t           ld,
    input  logic [BYTE_W-1:0]    ld_data,
    input  logic [ADDR_W-9:0]    start_page,
    input  logic [ADDR_W-9:0]    stop_page,
    input  logic                 word_mode,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic                 kick,
    input  logic                 stat_clr,
    output logic                 accept,
    output logic [ADDR_W-1:0]    cur_addr,
    output logic [ADDR_W-1:0]    cur_cnt,
    output logic                 done
);
    logic [ADDR_W-1:0] addr_q, cnt_q;
    logic [ADDR_W-1:0] step, sum, wrap_at, addr_adv, cnt_adv;
    logic              cnt_zero, last;
    logic              done_q;

    always_comb begin
        step     = word_mode ? ADDR_W'(2) : ADDR_W'(1);
        cnt_zero = (cnt_q == '0);
        accept   = host_req && !(host_we && cnt_zero);
        sum      = addr_q + step;
        wrap_at  = {stop_page, 8'h00};
        addr_adv = (sum == wrap_at) ? {start_page, 8'h00} : sum;
        last     = (cnt_q <= step);
        cnt_adv  = last ? '0 : cnt_q - step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= addr_adv;
                cnt_q  <= cnt_adv;
            end
            if (ld.addr_lo) addr_q[7:0]        <= ld_data;
            if (ld.addr_hi) addr_q[ADDR_W-1:8] <= ld_data[ADDR_W-9:0];
            if (ld.cnt_lo)  cnt_q[7:0]         <= ld_data;
            if (ld.cnt_hi)  cnt_q[ADDR_W-1:8]  <= ld_data[ADDR_W-9:0];
            if ((accept && last) || (kick && cnt_zero))
                done_q <= 1'b1;
            else if (stat_clr)
                done_q <= 1'b0;
        end
    end

    assign cur_addr = addr_q;
    assign cur_cnt  = cnt_q;
    assign done     = done_q;

endmodule

// File: rtl/rdma_lane.sv
module rdma_lane
    import rdma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOW_LIMIT = 32,
    parameter int HIGH_BASE = 16384,
    parameter int HIGH_END  = 49152
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic                 we,
    input  logic                 word,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [LANES-1:0]     mem_be,
    output logic [ADDR_W-2:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic                 rvalid,
    output logic [WORD_W-1:0]    rdata
);
    localparam logic [ADDR_W:0] LO_LIM = LOW_LIMIT[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_LO  = HIGH_BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_HI  = HIGH_END[ADDR_W:0];

    logic [ADDR_W-1:0] eff;
    logic [ADDR_W:0]   eff_x;
    logic              hit;
    rd_ctx_t           ctx_q;

    always_comb begin
        eff    = word ? {addr[ADDR_W-1:1], 1'b0} : addr;
        eff_x  = {1'b0, eff};
        hit    = (eff_x < LO_LIM) || ((eff_x >= HI_LO) && (eff_x < HI_HI));
        mem_en   = accept && hit;
        mem_we   = we;
        mem_addr = eff[ADDR_W-1:1];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mem_be[i]                   = word || (addr[0] == i[0]);
        assign mem_wdata[i*BYTE_W +: BYTE_W] = word ? wdata[i*BYTE_W +: BYTE_W]
                                                    : wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else begin
            ctx_q.valid <= accept && !we;
            ctx_q.hit   <= hit;
            ctx_q.word  <= word;
            ctx_q.lane  <= addr[0];
        end
    end

    always_comb begin
        if (!ctx_q.valid)
            rdata = '0;
        else if (!ctx_q.hit)
            rdata = ctx_q.word ? '1 : {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        else if (ctx_q.word)
            rdata = mem_rdata;
        else
            rdata = {{(WORD_W-BYTE_W){1'b0}},
                     ctx_q.lane ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0]};
    end

    assign rvalid = ctx_q.valid;

endmodule

// File: rtl/rdma_host_port.sv
module rdma_host_port
    import rdma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOW_LIMIT = 32,
    parameter int HIGH_BASE = 16384,
    parameter int HIGH_END  = 49152
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [LANES-1:0]     mem_be,
    output logic [ADDR_W-2:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 dma_done
);
    logic [ADDR_W-9:0] start_page, stop_page;
    logic              word_mode, kick, stat_clr, accept;
    ld_strobe_t        ld;
    logic [ADDR_W-1:0] cur_addr, cur_cnt;

    rdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .done(dma_done),
        .start_page(start_page), .stop_page(stop_page),
        .word_mode(word_mode), .ld(ld), .kick(kick), .stat_clr(stat_clr)
    );

    rdma_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk(clk), .rst(rst),
        .ld(ld), .ld_data(reg_wdata),
        .start_page(start_page), .stop_page(stop_page),
        .word_mode(word_mode),
        .host_req(host_req), .host_we(host_we),
        .kick(kick), .stat_clr(stat_clr),
        .accept(accept), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .done(dma_done)
    );

    rdma_lane #(
        .ADDR_W(ADDR_W), .LOW_LIMIT(LOW_LIMIT),
        .HIGH_BASE(HIGH_BASE), .HIGH_END(HIGH_END)
    ) u_lane (
        .clk(clk), .rst(rst),
        .accept(accept), .we(host_we), .word(word_mode),
        .addr(cur_addr), .wdata(host_wdata), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rvalid(host_rvalid), .rdata(host_rdata)
    );

endmodule

// File: rtl/rdma_host_port_chk.sv
module rdma_host_port_chk #(
    parameter int ADDR_W    = 16,
    parameter int LOW_LIMIT = 32,
    parameter int HIGH_BASE = 16384,
    parameter int HIGH_END  = 49152
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              host_req,
    input logic              host_we,
    input logic              host_rvalid,
    input logic              mem_en,
    input logic [1:0]        mem_be,
    input logic [ADDR_W-2:0] mem_addr,
    input logic              dma_done,
    input logic [ADDR_W-1:0] cnt,
    input logic              word
);
    localparam logic [ADDR_W:0] LO_LIM = LOW_LIMIT[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_LO  = HIGH_BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_HI  = HIGH_END[ADDR_W:0];

    logic [ADDR_W:0]   byte_addr;
    logic [ADDR_W-1:0] sz;
    logic              in_win;

    assign byte_addr = {1'b0, mem_addr, 1'b0};
    assign in_win    = (byte_addr < LO_LIM) || ((byte_addr >= HI_LO) && (byte_addr < HI_HI));
    assign sz        = word ? ADDR_W'(2) : ADDR_W'(1);

    // R5: completion only appears with the count exhausted
    p_done_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_done) && !$past(reg_wr) |-> cnt == '0);

    // R5: ordinary step of the count
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        host_req && !(host_we && cnt == '0) && (cnt > sz) && !reg_wr
        |=> cnt == $past(cnt) - $past(sz));

    p_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        host_req && host_we && cnt == '0 |-> !mem_en);

    p_window_r8: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> in_win);

    p_word_lanes_r9: assert property (@(posedge clk) disable iff (rst)
        mem_en && word |-> mem_be == 2'b11);

    p_byte_lane_r10: assert property (@(posedge clk) disable iff (rst)
        mem_en && !word |-> $countones(mem_be) == 1);

    p_read_resp_r11: assert property (@(posedge clk) disable iff (rst)
        host_req && !host_we |=> host_rvalid);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !host_req |=> !host_rvalid);

endmodule

bind rdma_host_port rdma_host_port_chk #(
    .ADDR_W(ADDR_W), .LOW_LIMIT(LOW_LIMIT),
    .HIGH_BASE(HIGH_BASE), .HIGH_END(HIGH_END)
) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr),
    .host_req(host_req), .host_we(host_we), .host_rvalid(host_rvalid),
    .mem_en(mem_en), .mem_be(mem_be), .mem_addr(mem_addr),
    .dma_done(dma_done), .cnt(cur_cnt), .word(word_mode)
);

// File: tb/test_rdma_host_port.sv
`timescale 1ns/1ps
module test_rdma_host_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        mem_en, mem_we;
    logic [1:0]  mem_be;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        dma_done;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    rdma_host_port i_rdma_host_port (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .host_req(host_req), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_done(dma_done)
    );

    // RAM model: read word = {low byte of word address ^ 3C, low byte of word address}
    always @(posedge clk)
        if (mem_en && !mem_we)
            mem_rdata <= {mem_addr[7:0] ^ 8'h3C, mem_addr[7:0]};

    typedef struct packed {
        logic        word;
        logic [15:0] wd;
        logic [1:0]  be;
        logic [14:0] wa;
        logic [15:0] ewd;
        logic [15:0] na;
        logic [15:0] nc;
        logic        dn;
    } vec_t;

    // ring 0x4000..0x47FF, start address 0x47FD, count 7, writes only
    localparam vec_t VEC [5] = '{
        '{1'b0, 16'h00A5, 2'b10, 15'h23FE, 16'hA5A5, 16'h47FE, 16'd6, 1'b0},
        '{1'b1, 16'h1234, 2'b11, 15'h23FF, 16'h1234, 16'h4000, 16'd4, 1'b0},
        '{1'b1, 16'hBEEF, 2'b11, 15'h2000, 16'hBEEF, 16'h4002, 16'd2, 1'b0},
        '{1'b0, 16'h0077, 2'b01, 15'h2001, 16'h7777, 16'h4003, 16'd1, 1'b0},
        '{1'b1, 16'hCAFE, 2'b11, 15'h2001, 16'hCAFE, 16'h4005, 16'd0, 1'b1}
    };

    logic        s_en;
    logic [1:0]  s_be;
    logic [14:0] s_wa;
    logic [15:0] s_wd;
    logic        s_rv;
    logic [15:0] s_rd;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rreg(lo, l);
        rreg(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic set_addr(input logic [15:0] a);
        wreg(4'd3, a[7:0]);
        wreg(4'd4, a[15:8]);
    endtask

    task automatic set_cnt(input logic [15:0] c);
        wreg(4'd5, c[7:0]);
        wreg(4'd6, c[15:8]);
    endtask

    task automatic acc(input logic we, input logic [15:0] wd);
        host_req = 1'b1; host_we = we; host_wdata = wd;
        #1;
        s_en = mem_en; s_be = mem_be; s_wa = mem_addr; s_wd = mem_wdata;
        @(posedge clk); @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        #1;
        s_rv = host_rvalid; s_rd = host_rdata;
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd16(4'd3, v); chk("R1", "addr", v, 16'h0000);
        rd16(4'd5, v); chk("R1", "count", v, 16'h0000);
        rreg(4'd8, b); chk("R1", "status", b, 8'h00);
        rreg(4'd7, b); chk("R1", "config", b, 8'h00);
        chk("R1", "rvalid", host_rvalid, 1'b0);

        // R2/R4 setup: ring pages 0x40..0x48
        wreg(4'd1, 8'h40);
        wreg(4'd2, 8'h48);
        rreg(4'd2, b); chk("R2", "stop page readback", b, 8'h48);
        set_addr(16'h47FD);
        set_cnt(16'd7);

        // vector walk: R3 R4 R5 R9 R10
        foreach (VEC[i]) begin
            wreg(4'd7, {7'b0, VEC[i].word});
            acc(1'b1, VEC[i].wd);
            chk("R9/R10", "mem_en", s_en, 1'b1);
            chk("R9/R10", "mem_be", s_be, VEC[i].be);
            chk("R9/R10", "mem_addr", s_wa, VEC[i].wa);
            chk("R9/R10", "mem_wdata", s_wd, VEC[i].ewd);
            rd16(4'd3, v); chk("R3/R4", "addr after", v, VEC[i].na);
            rd16(4'd5, v); chk("R5", "count after", v, VEC[i].nc);
            chk("R5", "done", dma_done, VEC[i].dn);
        end
        rreg(4'd8, b); chk("R2", "status bit 6", b, 8'h40);

        // R2: clear completion
        wreg(4'd8, 8'h40);
        chk("R2", "done cleared", dma_done, 1'b0);

        // R6: write with zero count ignored
        acc(1'b1, 16'h5555);
        chk("R6", "no mem_en", s_en, 1'b0);
        rd16(4'd3, v); chk("R6", "addr unchanged", v, 16'h4005);
        rd16(4'd5, v); chk("R6", "count unchanged", v, 16'h0000);
        chk("R6", "done unchanged", dma_done, 1'b0);

        // R7: command with remote-read bit at zero count
        wreg(4'd0, 8'h08);
        chk("R7", "zero count kick", dma_done, 1'b1);
        wreg(4'd8, 8'h40);
        set_cnt(16'd2);
        wreg(4'd0, 8'h10);
        chk("R7", "nonzero count no kick", dma_done, 1'b0);

        // R8: outside windows
        wreg(4'd7, 8'h00);
        set_addr(16'h0100);
        set_cnt(16'd4);
        acc(1'b1, 16'h00AA);
        chk("R8", "write discarded", s_en, 1'b0);
        rd16(4'd3, v); chk("R8", "addr advances", v, 16'h0101);
        rd16(4'd5, v); chk("R8", "count advances", v, 16'd3);
        wreg(4'd7, 8'h01);
        set_addr(16'h0200);
        acc(1'b0, 16'h0000);
        chk("R8", "word read no mem_en", s_en, 1'b0);
        chk("R11", "rvalid", s_rv, 1'b1);
        chk("R8", "word read ones", s_rd, 16'hFFFF);
        wreg(4'd7, 8'h00);
        set_addr(16'hC000);
        acc(1'b0, 16'h0000);
        chk("R8", "49152 outside", s_en, 1'b0);
        chk("R8", "byte read ones", s_rd, 16'h00FF);
        chk("R5", "done after last read", dma_done, 1'b1);

        // R8 boundaries, R10 byte read lanes
        set_cnt(16'd20);
        set_addr(16'hBFFF);
        acc(1'b0, 16'h0000);
        chk("R8", "49151 inside", s_en, 1'b1);
        chk("R10", "odd lane", s_rd, 16'h00C3);
        set_addr(16'h3FFF);
        acc(1'b0, 16'h0000);
        chk("R8", "16383 outside", s_en, 1'b0);
        acc(1'b0, 16'h0000);
        chk("R8", "16384 inside", s_en, 1'b1);
        chk("R10", "even lane", s_rd, 16'h0000 | 8'h00);
        set_addr(16'h001F);
        acc(1'b0, 16'h0000);
        chk("R8", "31 inside", s_en, 1'b1);
        acc(1'b0, 16'h0000);
        chk("R8", "32 outside", s_en, 1'b0);
        set_addr(16'h0005);
        acc(1'b0, 16'h0000);
        chk("R10", "byte be", s_be, 2'b10);
        chk("R10", "byte read data", s_rd, 16'h003E);

        // R9: word read at odd address uses even word, little-endian
        wreg(4'd7, 8'h01);
        set_addr(16'h0011);
        acc(1'b0, 16'h0000);
        chk("R9", "word addr", s_wa, 15'h0008);
        chk("R9", "word read data", s_rd, 16'h3408);
        rd16(4'd3, v); chk("R3", "odd word step", v, 16'h0013);

        finish_run();
    end

endmodule